// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block chooses where each of the two ALU operands of a five-stage in-order pipeline comes from while an instruction sits in the execute stage. It compares the two source register numbers of that instruction with the destination numbers of the two older instructions still in flight, one in the memory stage and one in the writeback stage. For each operand it forms a 2-bit select that picks one of three values: the one read from the register file, the ALU result held in the memory stage, or the result being written back.

A thin wrapper captures all of its inputs in one register stage on the rising clock edge. It then drives both the selects and the chosen operand words from that captured state. The register file writes early in a cycle and reads late in it, so a value written back in a given cycle already reaches a reader in that cycle. For that reason the operand-select logic only has to cover the two in-flight older instructions. Hazard stalls, the register file and the ALU are separate blocks.

Top module: `fwd_unit_top`

## Requirements
- R1: While reset is high at a rising edge, the next outputs are both selects equal to 2'b00 and both operand words equal to zero.
- R2: If the memory-stage instruction writes a register, its destination is nonzero, and that destination equals the execute-stage rs, the operand A select is 2'b10 and operand A equals the memory-stage result.
- R3: If only the writeback-stage instruction meets the same three conditions for rs, the operand A select is 2'b01 and operand A equals the writeback-stage result.
- R4: If both older instructions match the same source register, the memory-stage result is chosen (select 2'b10), because it is the more recent value.
- R5: Register number zero is never forwarded. A source of zero, or an older destination of zero, leaves the select at 2'b00 and the operand equal to the register-file value.
- R6: An older instruction whose write flag is low is never forwarded, even if its destination matches.
- R7: Operand B follows the rules of R2 to R6 using rt in place of rs, and it is decided independently of operand A.
- R8: The outputs reflect inputs sampled at the most recent rising edge. An input change between edges does not alter the outputs until the next edge.
- R9: A select value of 2'b11 is never produced.
- R10: Across a back-to-back sequence of dependent instructions, each operand equals the architecturally correct value of its source register, that is, the result of the latest older writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ex_rs_i | input | 5 | Execute-stage first source register |
| ex_rt_i | input | 5 | Execute-stage second source register |
| rf_a_i | input | 32 | Register-file value for the first source |
| rf_b_i | input | 32 | Register-file value for the second source |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_rd_i | input | 5 | Memory-stage destination register |
| mem_res_i | input | 32 | Memory-stage ALU result |
| wb_wr_i | input | 1 | Writeback-stage instruction writes a register |
| wb_rd_i | input | 5 | Writeback-stage destination register |
| wb_res_i | input | 32 | Writeback-stage result |
| sel_a_o | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 writeback |
| sel_b_o | output | 2 | Operand B source, same encoding |
| opnd_a_o | output | 32 | Selected operand A |
| opnd_b_o | output | 32 | Selected operand B |

## Verification
A bad captured destination, write flag or source register shows up as a wrong select code and a wrong operand word. It appears in the cycle right after the edge that captured the bad input, since nothing holds state for longer than one edge. Priority errors are only visible when both older stages name the same register, so the bench builds that case on purpose. The closed-loop instruction sequence feeds each forwarded result into later operands. As a result, one wrong choice also corrupts the values checked in the next few cycles.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    parameter int unsigned REG_W  = 5;
    parameter int unsigned DATA_W = 32;
    localparam int unsigned N_OPND = 2;

    typedef logic [REG_W-1:0]  reg_idx_t;
    typedef logic [DATA_W-1:0] word_t;

    // Operand source encoding; the two forwarding codes are one-hot.
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic     wr;
        reg_idx_t rd;
    } dst_t;

    typedef struct packed {
        dst_t  dst;
        word_t res;
    } older_t;

    // True when an older instruction supplies a usable value for src.
    function automatic logic dst_hits(dst_t d, reg_idx_t src);
        return d.wr && (d.rd != '0) && (d.rd == src);
    endfunction

endpackage

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
    import fwd_pkg::*;
(
    input  reg_idx_t src,
    input  dst_t     mem_dst,
    input  dst_t     wb_dst,
    output fwd_sel_e sel
);
    // The memory stage is checked last so that it overrides the writeback stage.
    always_comb begin
        sel = SEL_RF;
        if (dst_hits(wb_dst, src))
            sel = SEL_WB;
        if (dst_hits(mem_dst, src))
            sel = SEL_MEM;
    end
endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux
    import fwd_pkg::*;
(
    input  fwd_sel_e sel,
    input  word_t    rf_val,
    input  word_t    mem_val,
    input  word_t    wb_val,
    output word_t    y
);
    always_comb begin
        unique case (sel)
            SEL_MEM: y = mem_val;
            SEL_WB:  y = wb_val;
            default: y = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
    import fwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  ex_rs_i,
    input  logic [REG_W-1:0]  ex_rt_i,
    input  logic [DATA_W-1:0] rf_a_i,
    input  logic [DATA_W-1:0] rf_b_i,
    input  logic              mem_wr_i,
    input  logic [REG_W-1:0]  mem_rd_i,
    input  logic [DATA_W-1:0] mem_res_i,
    input  logic              wb_wr_i,
    input  logic [REG_W-1:0]  wb_rd_i,
    input  logic [DATA_W-1:0] wb_res_i,
    output logic [1:0]        sel_a_o,
    output logic [1:0]        sel_b_o,
    output logic [DATA_W-1:0] opnd_a_o,
    output logic [DATA_W-1:0] opnd_b_o
);
    reg_idx_t src_d  [N_OPND];
    word_t    rfv_d  [N_OPND];
    reg_idx_t src_q  [N_OPND];
    word_t    rfv_q  [N_OPND];
    older_t   mem_q;
    older_t   wb_q;
    fwd_sel_e sel    [N_OPND];
    word_t    opnd   [N_OPND];

    assign src_d[0] = ex_rs_i;
    assign src_d[1] = ex_rt_i;
    assign rfv_d[0] = rf_a_i;
    assign rfv_d[1] = rf_b_i;

    // Single capture stage for everything the selector looks at.
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
            wb_q  <= '0;
        end else begin
            mem_q <= '{dst: '{wr: mem_wr_i, rd: mem_rd_i}, res: mem_res_i};
            wb_q  <= '{dst: '{wr: wb_wr_i,  rd: wb_rd_i},  res: wb_res_i};
        end
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[g] <= '0;
                rfv_q[g] <= '0;
            end else begin
                src_q[g] <= src_d[g];
                rfv_q[g] <= rfv_d[g];
            end
        end

        fwd_src_pick u_pick (
            .src     (src_q[g]),
            .mem_dst (mem_q.dst),
            .wb_dst  (wb_q.dst),
            .sel     (sel[g])
        );

        fwd_opnd_mux u_mux (
            .sel     (sel[g]),
            .rf_val  (rfv_q[g]),
            .mem_val (mem_q.res),
            .wb_val  (wb_q.res),
            .y       (opnd[g])
        );
    end

    assign sel_a_o  = sel[0];
    assign sel_b_o  = sel[1];
    assign opnd_a_o = opnd[0];
    assign opnd_b_o = opnd[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
    import fwd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [REG_W-1:0]  ex_rs_i,
    input logic [REG_W-1:0]  ex_rt_i,
    input logic [DATA_W-1:0] rf_a_i,
    input logic [DATA_W-1:0] rf_b_i,
    input logic              mem_wr_i,
    input logic [REG_W-1:0]  mem_rd_i,
    input logic [DATA_W-1:0] mem_res_i,
    input logic              wb_wr_i,
    input logic [REG_W-1:0]  wb_rd_i,
    input logic [DATA_W-1:0] wb_res_i,
    input logic [1:0]        sel_a_o,
    input logic [1:0]        sel_b_o,
    input logic [DATA_W-1:0] opnd_a_o,
    input logic [DATA_W-1:0] opnd_b_o
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_a_o == 2'b00 && sel_b_o == 2'b00 &&
                        opnd_a_o == '0 && opnd_b_o == '0));

    p_mem_pick_a_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && mem_wr_i && mem_rd_i != '0 && mem_rd_i == ex_rs_i)
        |-> (sel_a_o == 2'b10 && opnd_a_o == $past(mem_res_i)));

    p_wb_pick_a_r3: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wb_wr_i && wb_rd_i != '0 && wb_rd_i == ex_rs_i &&
              !(mem_wr_i && mem_rd_i == ex_rs_i))
        |-> (sel_a_o == 2'b01 && opnd_a_o == $past(wb_res_i)));

    p_zero_src_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && ex_rs_i == '0) |-> (sel_a_o == 2'b00 && opnd_a_o == $past(rf_a_i)));

    p_mem_pick_b_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && mem_wr_i && mem_rd_i != '0 && mem_rd_i == ex_rt_i)
        |-> (sel_b_o == 2'b10 && opnd_b_o == $past(mem_res_i)));

    p_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !mem_wr_i && !wb_wr_i)
        |-> (sel_a_o == 2'b00 && sel_b_o == 2'b00));

    p_no_code3_r9: assert property (@(posedge clk) disable iff (rst)
        (sel_a_o != 2'b11 && sel_b_o != 2'b11));
endmodule

bind fwd_unit_top fwd_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ex_rs_i   (ex_rs_i),
    .ex_rt_i   (ex_rt_i),
    .rf_a_i    (rf_a_i),
    .rf_b_i    (rf_b_i),
    .mem_wr_i  (mem_wr_i),
    .mem_rd_i  (mem_rd_i),
    .mem_res_i (mem_res_i),
    .wb_wr_i   (wb_wr_i),
    .wb_rd_i   (wb_rd_i),
    .wb_res_i  (wb_res_i),
    .sel_a_o   (sel_a_o),
    .sel_b_o   (sel_b_o),
    .opnd_a_o  (opnd_a_o),
    .opnd_b_o  (opnd_b_o)
);

// File: tb/fwd_unit_top_test.sv
`timescale 1ns/1ps
module fwd_unit_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  ex_rs_i = '0, ex_rt_i = '0, mem_rd_i = '0, wb_rd_i = '0;
    logic [31:0] rf_a_i = '0, rf_b_i = '0, mem_res_i = '0, wb_res_i = '0;
    logic        mem_wr_i = 1'b0, wb_wr_i = 1'b0;
    logic [1:0]  sel_a_o, sel_b_o;
    logic [31:0] opnd_a_o, opnd_b_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    fwd_unit_top uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] rs, input logic [4:0] rt,
                         input logic [31:0] ra, input logic [31:0] rb,
                         input logic mw, input logic [4:0] mr, input logic [31:0] mv,
                         input logic ww, input logic [4:0] wr, input logic [31:0] wv);
        @(negedge clk);
        ex_rs_i = rs; ex_rt_i = rt; rf_a_i = ra; rf_b_i = rb;
        mem_wr_i = mw; mem_rd_i = mr; mem_res_i = mv;
        wb_wr_i = ww; wb_rd_i = wr; wb_res_i = wv;
    endtask

    task automatic settle();
        @(posedge clk); #1;
        chk("R9 sel_a", {31'd0, sel_a_o == 2'b11}, 32'd0);
        chk("R9 sel_b", {31'd0, sel_b_o == 2'b11}, 32'd0);
    endtask

    task automatic t_reset();
        drive(5'd3, 5'd3, 32'h11, 32'h22, 1'b1, 5'd3, 32'h33, 1'b1, 5'd3, 32'h44);
        rst = 1'b1;
        settle();
        chk("R1 sel_a", {30'd0, sel_a_o}, 32'd0);
        chk("R1 sel_b", {30'd0, sel_b_o}, 32'd0);
        chk("R1 opnd_a", opnd_a_o, 32'd0);
        chk("R1 opnd_b", opnd_b_o, 32'd0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_mem_a();
        drive(5'd7, 5'd2, 32'hA0, 32'hB0, 1'b1, 5'd7, 32'hC0FFEE, 1'b1, 5'd9, 32'hDEAD);
        settle();
        chk("R2 sel_a", {30'd0, sel_a_o}, 32'd2);
        chk("R2 opnd_a", opnd_a_o, 32'hC0FFEE);
        chk("R7 sel_b idle", {30'd0, sel_b_o}, 32'd0);
        chk("R7 opnd_b rf", opnd_b_o, 32'hB0);
    endtask

    task automatic t_wb_a();
        drive(5'd9, 5'd4, 32'hA1, 32'hB1, 1'b1, 5'd7, 32'h1234, 1'b1, 5'd9, 32'h5678);
        settle();
        chk("R3 sel_a", {30'd0, sel_a_o}, 32'd1);
        chk("R3 opnd_a", opnd_a_o, 32'h5678);
    endtask

    task automatic t_both();
        drive(5'd12, 5'd12, 32'hA2, 32'hB2, 1'b1, 5'd12, 32'h1111, 1'b1, 5'd12, 32'h2222);
        settle();
        chk("R4 sel_a", {30'd0, sel_a_o}, 32'd2);
        chk("R4 opnd_a", opnd_a_o, 32'h1111);
        chk("R4 sel_b", {30'd0, sel_b_o}, 32'd2);
        chk("R4 opnd_b", opnd_b_o, 32'h1111);
    endtask

    task automatic t_zero();
        drive(5'd0, 5'd0, 32'hA3, 32'hB3, 1'b1, 5'd0, 32'h3333, 1'b1, 5'd0, 32'h4444);
        settle();
        chk("R5 sel_a", {30'd0, sel_a_o}, 32'd0);
        chk("R5 opnd_a", opnd_a_o, 32'hA3);
        chk("R5 opnd_b", opnd_b_o, 32'hB3);
    endtask

    task automatic t_nowrite();
        drive(5'd5, 5'd6, 32'hA4, 32'hB4, 1'b0, 5'd5, 32'h5555, 1'b0, 5'd6, 32'h6666);
        settle();
        chk("R6 sel_a", {30'd0, sel_a_o}, 32'd0);
        chk("R6 opnd_a", opnd_a_o, 32'hA4);
        chk("R6 opnd_b", opnd_b_o, 32'hB4);
    endtask

    task automatic t_opnd_b();
        drive(5'd3, 5'd8, 32'hA5, 32'hB5, 1'b1, 5'd3, 32'h7777, 1'b1, 5'd8, 32'h8888);
        settle();
        chk("R7 sel_a", {30'd0, sel_a_o}, 32'd2);
        chk("R7 sel_b", {30'd0, sel_b_o}, 32'd1);
        chk("R7 opnd_b", opnd_b_o, 32'h8888);
    endtask

    task automatic t_latency();
        drive(5'd10, 5'd11, 32'hA6, 32'hB6, 1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 32'h0);
        settle();
        @(negedge clk);
        ex_rs_i = 5'd10; mem_wr_i = 1'b1; mem_rd_i = 5'd10; mem_res_i = 32'h9999;
        #1;
        chk("R8 hold sel_a", {30'd0, sel_a_o}, 32'd0);
        chk("R8 hold opnd_a", opnd_a_o, 32'hA6);
        settle();
        chk("R8 update sel_a", {30'd0, sel_a_o}, 32'd2);
        chk("R8 update opnd_a", opnd_a_o, 32'h9999);
    endtask

    // Closed-loop sequence against a reference register-file model (R10).
    localparam int NI = 10;
    logic [4:0]  q_rd [NI] = '{5'd1, 5'd4, 5'd5, 5'd1, 5'd1, 5'd6, 5'd0, 5'd7, 5'd6, 5'd8};
    logic [4:0]  q_rs [NI] = '{5'd2, 5'd1, 5'd4, 5'd1, 5'd1, 5'd1, 5'd6, 5'd0, 5'd7, 5'd6};
    logic [4:0]  q_rt [NI] = '{5'd3, 5'd3, 5'd1, 5'd1, 5'd5, 5'd1, 5'd1, 5'd6, 5'd6, 5'd7};
    logic        q_wr [NI] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    logic [31:0] q_res [NI];

    function automatic logic [31:0] reg_after(input int n, input logic [4:0] r);
        if (r == 5'd0) return 32'd0;
        for (int j = n - 1; j >= 0; j--)
            if (q_wr[j] && q_rd[j] == r) return q_res[j];
        return {27'd0, r} * 32'd100 + 32'd5;
    endfunction

    task automatic t_sequence();
        for (int k = 0; k < NI; k++) begin
            logic [31:0] ea, eb;
            ea = reg_after(k, q_rs[k]);
            eb = reg_after(k, q_rt[k]);
            drive(q_rs[k], q_rt[k],
                  reg_after(k - 2 < 0 ? 0 : k - 2, q_rs[k]),
                  reg_after(k - 2 < 0 ? 0 : k - 2, q_rt[k]),
                  k >= 1 ? q_wr[k-1] : 1'b0, k >= 1 ? q_rd[k-1] : 5'd0,
                  k >= 1 ? q_res[k-1] : 32'd0,
                  k >= 2 ? q_wr[k-2] : 1'b0, k >= 2 ? q_rd[k-2] : 5'd0,
                  k >= 2 ? q_res[k-2] : 32'd0);
            settle();
            chk($sformatf("R10 instr %0d opnd_a", k), opnd_a_o, ea);
            chk($sformatf("R10 instr %0d opnd_b", k), opnd_b_o, eb);
            q_res[k] = ea + eb + k;
        end
    endtask

    initial begin
        for (int i = 0; i < NI; i++) q_res[i] = '0;
        repeat (3) @(posedge clk);
        t_reset();
        t_mem_a();
        t_wb_a();
        t_both();
        t_zero();
        t_nowrite();
        t_opnd_b();
        t_latency();
        t_sequence();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule